// File: doc/BRIEF.md
# Up/Down Reload Timer with Baud Output

A 16-bit timer/counter paired with a 16-bit reload/capture register. Software sets it up through a byte-wide register port. The counter then advances by one step on each enabled count event. A count event is either a pulse on the prescaled tick input or a falling edge on an external count pin. The control bits pick one of four uses:

- latch the running count on an external trigger edge;
- auto-reload while counting up;
- auto-reload in both directions, with the direction taken from the trigger pin;
- supply overflow pulses that a serial port uses as its receive and transmit timing.

In both directions the reload depends on the direction of travel. Counting up, the counter passes all-ones and loads the reload register. Counting down, it meets the reload register value and loads all-ones. A separate clock-out output can toggle on every such wrap, which gives a square wave whose rate is set by the reload value. The serial port that consumes the timing pulses is outside this block.

The inputs are assumed to be synchronous to `clk`. Edges on the two pins are found by comparing each pin with its value one cycle earlier.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset, every register reads zero: control, mode, count and reload. Both flags, the clock-out output and this timer's overflow pulse are zero, so the block starts in count-up-only mode.
- R2: A step happens only while the run bit (control bit 0) is set. When the source-select bit (control bit 3) is clear, each cycle with `tick_i` high is a step and the count pin is ignored. When it is set, each falling edge of `cnt_pin_i` is a step and `tick_i` is ignored.
- R3: In count-up-only mode (control bits 2, 4, 5 and mode bit 0 all clear), a step from FFFFh loads the reload value and sets the overflow flag (control bit 6). Any other step adds one.
- R4: In count-up-only mode with the trigger enable set (control bit 1), a falling edge on `trig_pin_i` loads the reload value and sets the external flag (control bit 7). If it coincides with a step from FFFFh, the count becomes the reload value and both flags are set.
- R5: With the direction-enable bit set (mode bit 0) and no capture or baud use, a high `trig_pin_i` counts up and a low one counts down. An up step from FFFFh loads the reload value. A down step taken while the count equals the reload value loads FFFFh. Both of these set the overflow flag. A down step from any other value subtracts one.
- R6: In the up/down mode of R5, the external flag toggles on every reload event of either direction, and trigger edges do not set it.
- R7: In capture mode (control bit 2, no baud use), steps add one and wrap from FFFFh to 0000h, setting the overflow flag. A trigger-enabled falling edge on `trig_pin_i` copies the count as it stood before that cycle's step into the reload register and sets the external flag, and the count still takes its step.
- R8: In baud mode (control bit 4 or 5 set, which takes precedence over every other mode) the counter counts up and reloads on overflow without setting the overflow flag. Reload events therefore come every 65536 minus reload steps. With a step every clock, and a serial port that divides by 16, the bit rate is f/(16·(65536−reload)). A trigger-enabled falling edge only sets the external flag.
- R9: `rx_tick_o` shows this timer's overflow pulse when control bit 4 is set and `alt_ovf_i` when it is clear. `tx_tick_o` does the same under control bit 5. The overflow pulse is high for the one cycle after a reload or wrap event.
- R10: When the clock-out bit (mode bit 1) is set and the source-select bit is clear, `clkout_o` toggles on every reload or wrap event of the counter. Otherwise it holds its value.
- R11: The register addresses are 0 control, 1 mode, 2 and 3 count low and high, and 4 and 5 reload low and high. Other addresses read zero. A write to a count byte replaces that byte and cancels the step for that cycle. A write to a reload byte wins over a capture in the same cycle. Writing control loads both flags from data bits 6 and 7, but a hardware set or toggle in the same cycle is applied on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| tick_i | input | 1 | Prescaled count tick |
| cnt_pin_i | input | 1 | External count pin (falling edges count) |
| trig_pin_i | input | 1 | Trigger pin, and direction level in up/down mode |
| alt_ovf_i | input | 1 | Overflow pulse of another timer |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| rx_tick_o | output | 1 | Receive timing pulse for the serial port |
| tx_tick_o | output | 1 | Transmit timing pulse for the serial port |
| clkout_o | output | 1 | Clock-out square wave |

## Verification
Two events can land in the same cycle: the trigger edge (a reload in count-up-only mode, a capture in capture mode) and a counting step, including the step from FFFFh. The directed cases line them up on purpose.

- A trigger falling edge arrives in the same cycle as the overflow step. The count must equal the reload value and both flags must be set.
- A capture edge arrives together with a step. The reload register must hold the pre-step count while the count moves on by one.

The random phases toggle the trigger pin and raise ticks independently, and an independent model computes the expected outputs. Any overlap they produce in any mode is judged on every cycle against that model's count, reload, flags and pulse outputs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int CW = 16;
  parameter int DW = 8;
  parameter int AW = 3;
  localparam int NB = CW / DW;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_MODE = 3'd1;
  localparam logic [AW-1:0] A_CNTL = 3'd2;
  localparam logic [AW-1:0] A_CNTH = 3'd3;
  localparam logic [AW-1:0] A_RLDL = 3'd4;
  localparam logic [AW-1:0] A_RLDH = 3'd5;

  typedef enum logic [1:0] {MD_UP, MD_UPDN, MD_CAP, MD_BAUD} tmr_mode_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= pin_i[i];
    end
    assign fall_o[i] = prev_q[i] & ~pin_i[i];
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode_i,
  input  logic          step_i,
  input  logic          up_i,
  input  logic          trig_fall_i,
  input  logic          ext_en_i,
  input  logic [NB-1:0] cnt_wr_i,
  input  logic [NB-1:0] rld_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output logic          wrap_o,
  output logic          ovf_set_o,
  output logic          ext_set_o,
  output logic          ext_tog_o
);
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_n, rld_q, rld_n;
  logic wrap, ovf_set, ext_set, ext_tog;
  logic at_top, at_rld, ext_hit;

  assign at_top  = (cnt_q == FULL);
  assign at_rld  = (cnt_q == rld_q);
  assign ext_hit = ext_en_i & trig_fall_i;

  always_comb begin
    cnt_n   = cnt_q;
    rld_n   = rld_q;
    wrap    = 1'b0;
    ovf_set = 1'b0;
    ext_set = 1'b0;
    ext_tog = 1'b0;
    unique case (mode_i)
      MD_BAUD: begin
        if (step_i) begin
          cnt_n = at_top ? rld_q : cnt_q + ONE;
          wrap  = at_top;
        end
        ext_set = ext_hit;
      end
      MD_CAP: begin
        if (step_i) begin
          cnt_n   = cnt_q + ONE;
          wrap    = at_top;
          ovf_set = at_top;
        end
        if (ext_hit) begin
          rld_n   = cnt_q;
          ext_set = 1'b1;
        end
      end
      MD_UPDN: begin
        if (step_i) begin
          if (up_i) begin
            cnt_n = at_top ? rld_q : cnt_q + ONE;
            wrap  = at_top;
          end else begin
            cnt_n = at_rld ? FULL : cnt_q - ONE;
            wrap  = at_rld;
          end
        end
        ovf_set = wrap;
        ext_tog = wrap;
      end
      default: begin
        if (step_i) begin
          cnt_n   = at_top ? rld_q : cnt_q + ONE;
          wrap    = at_top;
          ovf_set = at_top;
        end
        if (ext_hit) begin
          cnt_n   = rld_q;
          ext_set = 1'b1;
        end
      end
    endcase
    if (|cnt_wr_i) begin
      cnt_n   = cnt_q;
      wrap    = 1'b0;
      ovf_set = 1'b0;
      ext_tog = 1'b0;
      for (int b = 0; b < NB; b++)
        if (cnt_wr_i[b]) cnt_n[b*DW +: DW] = wdata_i;
    end
    if (|rld_wr_i) begin
      rld_n = rld_q;
      for (int b = 0; b < NB; b++)
        if (rld_wr_i[b]) rld_n[b*DW +: DW] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      rld_q <= rld_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign rld_o     = rld_q;
  assign wrap_o    = wrap;
  assign ovf_set_o = ovf_set;
  assign ext_set_o = ext_set;
  assign ext_tog_o = ext_tog;

  // R3: an up-only step from the top loads the reload value
  p_up_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_UP && step_i && cnt_q == FULL && !ext_hit && cnt_wr_i == '0)
    |=> cnt_q == $past(rld_q));

  // R5: a down step at the reload value lands on all-ones
  p_down_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_UPDN && step_i && !up_i && cnt_q == rld_q && cnt_wr_i == '0)
    |=> cnt_q == FULL);

  // R7: a capture without a step copies the count and leaves it alone
  p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_CAP && ext_hit && !step_i && cnt_wr_i == '0 && rld_wr_i == '0)
    |=> (rld_q == $past(cnt_q) && $stable(cnt_q)));
endmodule

// File: rtl/tmr_baud.sv
module tmr_baud (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic rx_sel_i,
  input  logic tx_sel_i,
  input  logic alt_ovf_i,
  input  logic clkout_en_i,
  output logic rx_tick_o,
  output logic tx_tick_o,
  output logic clkout_o
);
  logic pulse_q, pulse_n, co_q, co_n;

  always_comb begin
    pulse_n = wrap_i;
    co_n    = co_q ^ (wrap_i & clkout_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      co_q    <= 1'b0;
    end else begin
      pulse_q <= pulse_n;
      co_q    <= co_n;
    end
  end

  assign rx_tick_o = rx_sel_i ? pulse_q : alt_ovf_i;
  assign tx_tick_o = tx_sel_i ? pulse_q : alt_ovf_i;
  assign clkout_o  = co_q;

  // R10: the clock-out level only moves after an enabled wrap
  p_clkout_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clkout_o) |-> $past(wrap_i && clkout_en_i));
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          tick_i,
  input  logic          cnt_pin_i,
  input  logic          trig_pin_i,
  input  logic          alt_ovf_i,
  output logic          ovf_flag_o,
  output logic          ext_flag_o,
  output logic          rx_tick_o,
  output logic          tx_tick_o,
  output logic          clkout_o
);
  logic run_q, exten_q, cap_q, csel_q, rxs_q, txs_q, dcen_q, coen_q, ovf_q, ext_q;
  logic run_n, exten_n, cap_n, csel_n, rxs_n, txs_n, dcen_n, coen_n, ovf_n, ext_n;
  logic [1:0] fall;
  logic step, wrap, ovf_set, ext_set, ext_tog, ctrl_wr, mode_wr;
  logic [NB-1:0] cnt_wr, rld_wr;
  logic [CW-1:0] cnt, rld;
  tmr_mode_e mode;

  tmr_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .pin_i({trig_pin_i, cnt_pin_i}), .fall_o(fall)
  );

  assign step = run_q & (csel_q ? fall[0] : tick_i);

  always_comb begin
    if (rxs_q | txs_q) mode = MD_BAUD;
    else if (cap_q)    mode = MD_CAP;
    else if (dcen_q)   mode = MD_UPDN;
    else               mode = MD_UP;
  end

  assign ctrl_wr = wr_en_i && wr_addr_i == A_CTRL;
  assign mode_wr = wr_en_i && wr_addr_i == A_MODE;
  assign cnt_wr  = {wr_en_i && wr_addr_i == A_CNTH, wr_en_i && wr_addr_i == A_CNTL};
  assign rld_wr  = {wr_en_i && wr_addr_i == A_RLDH, wr_en_i && wr_addr_i == A_RLDL};

  tmr_count u_count (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .step_i(step), .up_i(trig_pin_i),
    .trig_fall_i(fall[1]), .ext_en_i(exten_q), .cnt_wr_i(cnt_wr), .rld_wr_i(rld_wr),
    .wdata_i(wr_data_i), .cnt_o(cnt), .rld_o(rld), .wrap_o(wrap),
    .ovf_set_o(ovf_set), .ext_set_o(ext_set), .ext_tog_o(ext_tog)
  );

  tmr_baud u_baud (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .rx_sel_i(rxs_q), .tx_sel_i(txs_q),
    .alt_ovf_i(alt_ovf_i), .clkout_en_i(coen_q & ~csel_q),
    .rx_tick_o(rx_tick_o), .tx_tick_o(tx_tick_o), .clkout_o(clkout_o)
  );

  always_comb begin
    {ext_n, ovf_n, txs_n, rxs_n, csel_n, cap_n, exten_n, run_n} =
      ctrl_wr ? wr_data_i : {ext_q, ovf_q, txs_q, rxs_q, csel_q, cap_q, exten_q, run_q};
    {coen_n, dcen_n} = mode_wr ? wr_data_i[1:0] : {coen_q, dcen_q};
    ovf_n = ovf_n | ovf_set;
    ext_n = (ext_n | ext_set) ^ ext_tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ext_q, ovf_q, txs_q, rxs_q, csel_q, cap_q, exten_q, run_q} <= '0;
      {coen_q, dcen_q} <= '0;
    end else begin
      {ext_q, ovf_q, txs_q, rxs_q, csel_q, cap_q, exten_q, run_q} <=
        {ext_n, ovf_n, txs_n, rxs_n, csel_n, cap_n, exten_n, run_n};
      {coen_q, dcen_q} <= {coen_n, dcen_n};
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = {ext_q, ovf_q, txs_q, rxs_q, csel_q, cap_q, exten_q, run_q};
      A_MODE:  rd_data_o = {6'd0, coen_q, dcen_q};
      A_CNTL:  rd_data_o = cnt[DW-1:0];
      A_CNTH:  rd_data_o = cnt[CW-1:DW];
      A_RLDL:  rd_data_o = rld[DW-1:0];
      A_RLDH:  rd_data_o = rld[CW-1:DW];
      default: rd_data_o = '0;
    endcase
  end

  assign ovf_flag_o = ovf_q;
  assign ext_flag_o = ext_q;

  // R8: the overflow flag never rises while baud use is running unchanged
  p_baud_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BAUD && !ctrl_wr) |=> !$rose(ovf_flag_o));
endmodule

// File: tb/sim_updn_reload_timer.sv
`timescale 1ns/1ps
module sim_updn_reload_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tick = 1'b0, cpin = 1'b0, tpin = 1'b0, alt = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic ovf_o, ext_o, rx_o, tx_o, co_o;
  int n_chk = 0, n_bad = 0;

  // independent model state
  logic [15:0] m_cnt, m_rld;
  logic m_run, m_een, m_cap, m_csel, m_rx, m_tx, m_ovf, m_ext, m_dcen, m_coen;
  logic m_tp, m_cp, m_pulse, m_co;

  always #2.5 clk = ~clk;

  updn_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .tick_i(tick), .cnt_pin_i(cpin),
    .trig_pin_i(tpin), .alt_ovf_i(alt), .ovf_flag_o(ovf_o), .ext_flag_o(ext_o),
    .rx_tick_o(rx_o), .tx_tick_o(tx_o), .clkout_o(co_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.2;
    d = rd_data;
  endtask

  function automatic int md_of();
    if (m_rx | m_tx) return 3;
    if (m_cap) return 2;
    if (m_dcen) return 1;
    return 0;
  endfunction

  task automatic model_step();
    logic tf, cf, step, ehit, at_top, wrap, ovs, exs, ext_t;
    logic [15:0] c, r;
    int md;
    tf = m_tp & ~tpin; cf = m_cp & ~cpin;
    step = m_run & (m_csel ? cf : tick);
    ehit = m_een & tf;
    md = md_of();
    c = m_cnt; r = m_rld; wrap = 0; ovs = 0; exs = 0; ext_t = 0;
    at_top = (m_cnt == 16'hFFFF);
    case (md)
      3: begin
        if (step) begin c = at_top ? m_rld : m_cnt + 16'd1; wrap = at_top; end
        exs = ehit;
      end
      2: begin
        if (step) begin c = m_cnt + 16'd1; wrap = at_top; ovs = at_top; end
        if (ehit) begin r = m_cnt; exs = 1; end
      end
      1: begin
        if (step) begin
          if (tpin) begin c = at_top ? m_rld : m_cnt + 16'd1; wrap = at_top; end
          else if (m_cnt == m_rld) begin c = 16'hFFFF; wrap = 1; end
          else c = m_cnt - 16'd1;
        end
        ovs = wrap; ext_t = wrap;
      end
      default: begin
        if (step) begin c = at_top ? m_rld : m_cnt + 16'd1; wrap = at_top; ovs = at_top; end
        if (ehit) begin c = m_rld; exs = 1; end
      end
    endcase
    if (wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3)) begin
      c = m_cnt; wrap = 0; ovs = 0; ext_t = 0;
      if (wr_addr == 3'd2) c[7:0] = wr_data; else c[15:8] = wr_data;
    end
    if (wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5)) begin
      r = m_rld;
      if (wr_addr == 3'd4) r[7:0] = wr_data; else r[15:8] = wr_data;
    end
    m_co = m_co ^ (wrap & m_coen & ~m_csel);
    m_pulse = wrap;
    if (wr_en && wr_addr == 3'd0) begin
      {m_ext, m_ovf, m_tx, m_rx, m_csel, m_cap, m_een, m_run} = wr_data;
    end
    if (wr_en && wr_addr == 3'd1) {m_coen, m_dcen} = wr_data[1:0];
    m_ovf = m_ovf | ovs;
    m_ext = (m_ext | exs) ^ ext_t;
    m_cnt = c; m_rld = r;
    m_tp = tpin; m_cp = cpin;
  endtask

  task automatic compare();
    logic [7:0] d;
    string tc, tf, te;
    int md;
    md = md_of();
    tc = (md == 3) ? "R8" : (md == 2) ? "R7" : (md == 1) ? "R5" : "R3";
    te = (md == 3) ? "R8" : (md == 2) ? "R7" : (md == 1) ? "R6" : "R4";
    tf = tc;
    rd(3'd2, d); chk({tc, " count lo"}, d, m_cnt[7:0]);
    rd(3'd3, d); chk({tc, " count hi"}, d, m_cnt[15:8]);
    rd(3'd4, d); chk({tc, " reload lo"}, d, m_rld[7:0]);
    rd(3'd5, d); chk({tc, " reload hi"}, d, m_rld[15:8]);
    rd(3'd0, d); chk("R11 control", d, {m_ext, m_ovf, m_tx, m_rx, m_csel, m_cap, m_een, m_run});
    rd(3'd1, d); chk("R11 mode", d, {6'd0, m_coen, m_dcen});
    chk({tf, " overflow flag"}, ovf_o, m_ovf);
    chk({te, " external flag"}, ext_o, m_ext);
    chk("R9 rx tick", rx_o, m_rx ? m_pulse : alt);
    chk("R9 tx tick", tx_o, m_tx ? m_pulse : alt);
    chk("R10 clkout", co_o, m_co);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rdv(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] a, b;
    rd(lo, a); rd(lo + 3'd1, b);
    v = {b, a};
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [7:0] d;
    int last, toggles;
    logic prev_co;
    void'($urandom(32'd1357));
    m_cnt = 0; m_rld = 0; {m_run, m_een, m_cap, m_csel, m_rx, m_tx, m_ovf, m_ext} = '0;
    m_dcen = 0; m_coen = 0; m_tp = 0; m_cp = 0; m_pulse = 0; m_co = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a[2:0], d); chk("R1 reset read", d, 8'h00); end
    chk("R1 reset flags", {ovf_o, ext_o, rx_o, tx_o, co_o}, 5'b0);
    rst_n = 1'b1;
    cyc();

    // R2: count-pin source, tick ignored
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h09);
    tick = 1; repeat (3) cyc();
    rdv(3'd2, v); chk("R2 tick ignored with pin source", v, 16'h0000);
    cpin = 1; cyc(); cpin = 0; cyc();
    rdv(3'd2, v); chk("R2 pin falling edge steps", v, 16'h0001);
    tick = 0; wr(3'd0, 8'h08); cpin = 1; cyc(); cpin = 0; cyc();
    rdv(3'd2, v); chk("R2 no step without run", v, 16'h0001);

    // R4: trigger reload coinciding with overflow step
    wr(3'd0, 8'h00); wr(3'd4, 8'h34); wr(3'd5, 8'h12); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    tpin = 1; cyc(); wr(3'd0, 8'h03);
    tick = 1; tpin = 0; cyc(); tick = 0;
    rdv(3'd2, v); chk("R4 coincident reload count", v, 16'h1234);
    chk("R4 coincident flags", {ovf_o, ext_o}, 2'b11);

    // R5/R6: down count to the reload value, then up through the top
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd4, 8'h05); wr(3'd5, 8'h00);
    wr(3'd2, 8'h06); wr(3'd3, 8'h00); wr(3'd0, 8'h01);
    tick = 1; cyc(); cyc(); tick = 0;
    rdv(3'd2, v); chk("R5 down step at reload gives FFFF", v, 16'hFFFF);
    chk("R6 toggle on underflow", {ovf_o, ext_o}, 2'b11);
    tpin = 1; tick = 1; cyc(); tick = 0;
    rdv(3'd2, v); chk("R5 up overflow reloads", v, 16'h0005);
    chk("R6 toggle on overflow", ext_o, 1'b0);

    // R7: capture together with a step
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h10); wr(3'd3, 8'h00); wr(3'd0, 8'h07);
    tick = 1; tpin = 0; cyc(); tick = 0;
    rdv(3'd4, v); chk("R7 captured pre-step count", v, 16'h0010);
    rdv(3'd2, v); chk("R7 count still stepped", v, 16'h0011);
    chk("R7 external flag", ext_o, 1'b1);

    // R8/R9: baud period for reload FFF0
    wr(3'd0, 8'h00); wr(3'd4, 8'hF0); wr(3'd5, 8'hFF); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h11);
    tick = 1; alt = 1; last = -1;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (rx_o) begin
        if (last >= 0) chk("R8 baud period", i - last, 16);
        last = i;
      end
    end
    tick = 0;
    chk("R8 no overflow flag", ovf_o, 1'b0);
    chk("R9 tx follows other timer", tx_o, 1'b1);
    alt = 0;

    // R10: clock-out toggles per wrap
    wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h01);
    tick = 1; toggles = 0; prev_co = co_o;
    for (int i = 0; i < 8; i++) begin
      cyc();
      if (co_o !== prev_co) toggles++;
      prev_co = co_o;
    end
    tick = 0;
    chk("R10 toggle count", toggles, 4);

    // R11: count write wins over a step
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h01);
    tick = 1; wr(3'd2, 8'h55); tick = 0;
    rdv(3'd2, v); chk("R11 write beats step", v, 16'h0155);

    // random phases
    for (int ph = 0; ph < 30; ph++) begin
      wr(3'd0, 8'h00);
      wr(3'd1, 8'($urandom_range(0, 3)));
      wr(3'd4, 8'($urandom));
      wr(3'd5, ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom));
      wr(3'd2, 8'($urandom));
      wr(3'd3, ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom));
      wr(3'd0, 8'($urandom) | 8'h01);
      for (int k = 0; k < 300; k++) begin
        tick = ($urandom_range(0, 9) < 7);
        if ($urandom_range(0, 3) == 0) cpin = ~cpin;
        if ($urandom_range(0, 4) == 0) tpin = ~tpin;
        alt = $urandom_range(0, 1);
        if ($urandom_range(0, 49) == 0) begin
          wr_en = 1; wr_addr = 3'($urandom_range(0, 5)); wr_data = 8'($urandom);
        end else wr_en = 0;
        cyc();
      end
      wr_en = 0; tick = 0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule